// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a small processor whose low address byte and data share one 8-bit multiplexed bus. The core hands it one request at a time: a read, a write or an interrupt acknowledge, a memory or I/O space bit, a 20-bit address and a write byte. The sequencer then steps through the bus states T1, T2, T3, any number of wait states Tw, and T4, and drives the address latch strobe, the read, write and acknowledge strobes, the space select, the transceiver direction and enable, and the output enable of the multiplexed bus.

Read and acknowledge strobes start half a clock into T2, so that the bus drivers are off before the addressed device drives the bus. A write strobe starts on the T2 clock edge, with the write byte already on the bus. An interrupt acknowledge runs as two cycles with no idle gap between them. Only the byte read in the second cycle is kept. That byte is the interrupt type, and the block also returns it multiplied by four as a pointer into the vector table. Every cycle ends with a one-clock done pulse in T4.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is high and every strobe, `ale`, `ad_oe` and `rsp_valid` are low. A request present while `req_ready` is high starts T1 on the next rising clock edge. `req_ready` stays low from T1 until the cycle returns to idle.
- R2: `ale` is high for exactly the T1 state of every cycle. For reads and writes, `ad_oe` is high in T1 and `ad_out` carries address bits 7:0. For an acknowledge, `ad_oe` stays low.
- R3: `addr_hi` shows address bits 19:8 of the request from T1 through T4 and keeps that value afterwards. An acknowledge request leaves `addr_hi` unchanged.
- R4: `io_sel` equals the request's space bit (1 = I/O, 0 = memory) from T1 through T4.
- R5: On a read, `ad_oe` is low from T2 through T4. `rd_stb` is low in the first half of T2, rises at the falling clock edge in the middle of T2, and is low again from the rising edge that starts T4.
- R6: On a write, `ad_out` carries the write byte with `ad_oe` high from T2 through T4. `wr_stb` is high from the rising edge that starts T2 through T3 and every Tw, and low in T4.
- R7: `ready` is sampled on each rising edge that ends T3 or Tw. A low sample inserts one more Tw, and a high sample moves to T4. The strobe and `rsp_valid` stay at their in-cycle values during every Tw.
- R8: `rsp_valid` is high for exactly the T4 clock of the final cycle of each request. On a read, `rsp_data` in that clock holds the `ad_in` value sampled at the edge that entered T4.
- R9: An acknowledge runs two back-to-back cycles, each with its own `ale` pulse. `inta_stb` takes the place and timing of `rd_stb`, and `rd_stb` stays low. `rsp_valid` is low in the first T4 and high in the second, and `rsp_data` is the byte from the second cycle.
- R10: After an acknowledge completes, `vec_ptr` equals the type byte shifted left by two bits.
- R11: `dt_tx` is high from T1 through T4 of a write and low on reads and acknowledges. `den` is high from T2 through T4 on a write, and from T2 through the last T3 or Tw on a read or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states change on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 0 read, 1 write, 2 interrupt acknowledge |
| req_io | input | 1 | 1 selects I/O space, 0 memory space |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| ready | input | 1 | Device ready, sampled at the end of T3 and Tw |
| ad_in | input | 8 | Multiplexed bus input |
| ad_out | output | 8 | Multiplexed bus output value |
| ad_oe | output | 1 | Multiplexed bus output enable |
| addr_hi | output | 12 | Address bits 19:8, held for the whole cycle |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| inta_stb | output | 1 | Interrupt acknowledge strobe |
| io_sel | output | 1 | Space select, 1 for I/O |
| dt_tx | output | 1 | Transceiver direction, 1 toward the bus |
| den | output | 1 | Transceiver enable |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_data | output | 8 | Captured read or type byte |
| vec_ptr | output | 10 | Type byte times four |

## Verification
The bench builds the block with its default parameters: a 20-bit address, an 8-bit bus and a shift of two for the vector pointer. Its device model can hold `ready` low for any number of clocks, so runs with zero, one, two and three wait states are all reachable. It samples each output once early in a clock and once after the falling edge, which resolves the half-clock offset between read and write strobes. A write placed before the acknowledge makes the held upper address bits visible during both acknowledge cycles.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int ADDR_W    = 20;
    localparam int DATA_W    = 8;
    localparam int VEC_SHIFT = 2;
    localparam int HI_W      = ADDR_W - DATA_W;
    localparam int VEC_W     = DATA_W + VEC_SHIFT;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_INTA  = 2'd2
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } bus_state_e;

    typedef struct packed {
        cyc_kind_e          kind;
        logic               io;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
    } bus_req_t;

    // States in which a command strobe may be active
    function automatic logic in_strobe_window(input bus_state_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [DATA_W-1:0] t);
        return {t, {VEC_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  cyc_kind_e  kind,
    input  logic       ready,
    output bus_state_e state,
    output logic       capture,
    output logic       done
);
    bus_state_e nxt;
    logic       second;
    logic       last_cycle;
    logic       leave_wait;

    assign last_cycle = (kind != KIND_INTA) || second;
    assign leave_wait = ((state == ST_T3) || (state == ST_TW)) && ready;
    assign capture    = leave_wait && last_cycle && (kind != KIND_WRITE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3,
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4:   nxt = last_cycle ? ST_IDLE : ST_T1;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            second <= 1'b0;
            done   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= leave_wait && last_cycle;
            if (state == ST_IDLE)
                second <= 1'b0;
            else if (state == ST_T4)
                second <= 1'b1;
        end
    end

    p_wait_on_low_ready_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_T3 || state == ST_TW) && !ready) |=> (state == ST_TW));

    p_advance_on_ready_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_T3 || state == ST_TW) && ready) |=> (state == ST_T4));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_in_t4_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_T4));

endmodule

// File: rtl/mbus_half_edge.sv
module mbus_half_edge (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    // Falling-edge stage: moves a level into the middle of the clock
    always_ff @(negedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
    import mbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  bus_req_t            req,
    input  logic                capture,
    input  logic [DATA_W-1:0]   ad_in,
    output bus_req_t            cur,
    output logic [DATA_W-1:0]   rdata,
    output logic [VEC_W-1:0]    vec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            rdata <= '0;
            vec   <= '0;
        end else begin
            if (accept) begin
                cur.kind  <= req.kind;
                cur.io    <= req.io;
                cur.wdata <= req.wdata;
                // Acknowledge keeps the previous address on the pins
                if (req.kind != KIND_INTA)
                    cur.addr <= req.addr;
            end
            if (capture) begin
                rdata <= ad_in;
                if (cur.kind == KIND_INTA)
                    vec <= vec_of(ad_in);
            end
        end
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_io,
    input  logic [19:0]       req_addr,
    input  logic [7:0]        req_wdata,
    output logic              req_ready,
    input  logic              ready,
    input  logic [7:0]        ad_in,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    output logic [11:0]       addr_hi,
    output logic              ale,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              inta_stb,
    output logic              io_sel,
    output logic              dt_tx,
    output logic              den,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic [9:0]        vec_ptr
);
    bus_state_e state;
    bus_req_t   req, cur;
    logic       accept, capture, win, is_wr, is_inta, active, late_q;

    assign req    = '{kind: cyc_kind_e'(req_kind), io: req_io,
                      addr: req_addr, wdata: req_wdata};
    assign accept = req_valid && (state == ST_IDLE);

    mbus_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (req_valid),
        .kind    (cur.kind),
        .ready   (ready),
        .state   (state),
        .capture (capture),
        .done    (rsp_valid)
    );

    mbus_datapath u_dp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .req     (req),
        .capture (capture),
        .ad_in   (ad_in),
        .cur     (cur),
        .rdata   (rsp_data),
        .vec     (vec_ptr)
    );

    assign win     = in_strobe_window(state);
    assign is_wr   = (cur.kind == KIND_WRITE);
    assign is_inta = (cur.kind == KIND_INTA);
    assign active  = (state != ST_IDLE);

    mbus_half_edge u_half (
        .clk (clk),
        .rst (rst),
        .d   (win && !is_wr),
        .q   (late_q)
    );

    assign req_ready = (state == ST_IDLE);
    assign ale       = (state == ST_T1);
    assign ad_oe     = active && !is_inta && ((state == ST_T1) || is_wr);
    assign ad_out    = (state == ST_T1) ? cur.addr[DATA_W-1:0] : cur.wdata;
    assign addr_hi   = cur.addr[ADDR_W-1:DATA_W];
    assign io_sel    = cur.io;
    assign wr_stb    = is_wr && win;
    assign rd_stb    = late_q && win && (cur.kind == KIND_READ);
    assign inta_stb  = late_q && win && is_inta;
    assign dt_tx     = active && is_wr;
    assign den       = is_wr ? (win || state == ST_T4) : win;

    p_req_starts_t1_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (ale && !req_ready));

    p_ale_no_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        ale |-> !(rd_stb || wr_stb || inta_stb));

    p_read_bus_released_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || inta_stb) |-> !ad_oe);

    p_write_bus_driven_r6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (ad_oe && dt_tx));

    p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb, wr_stb, inta_stb}));

    p_hi_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (active && !ale) |-> $stable(addr_hi));

endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_io;
    logic [19:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic        ready;
    logic [7:0]  ad_in;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [11:0] addr_hi;
    logic        ale, rd_stb, wr_stb, inta_stb, io_sel, dt_tx, den, rsp_valid;
    logic [7:0]  rsp_data;
    logic [9:0]  vec_ptr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [11:0] last_hi = '0;
    bit finished = 0;

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_IA = 2'd2;

    always #10 clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .inta_stb(inta_stb), .io_sel(io_sel), .dt_tx(dt_tx),
        .den(den), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .vec_ptr(vec_ptr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic next_early();
        @(posedge clk); #4;
    endtask

    // Issue a request from idle; returns at the early point of T1
    task automatic launch(input logic [1:0] k, input logic io,
                          input logic [19:0] a, input logic [7:0] wd);
        chk("R1", "req_ready before issue", req_ready, 1);
        req_valid = 1; req_kind = k; req_io = io; req_addr = a; req_wdata = wd;
        next_early();
        req_valid = 0;
    endtask

    // One bus cycle from T1 early to the early point after T4
    task automatic phase(input logic [1:0] k, input logic io, input logic [19:0] a,
                         input logic [7:0] wd, input logic [7:0] rb,
                         input int waits, input bit fin, input logic [11:0] hi);
        bit w;
        w = (k == K_WR);
        // T1
        chk("R2", "ale T1", ale, 1);
        chk("R2", "ad_oe T1", ad_oe, (k != K_IA));
        if (k != K_IA) chk("R2", "ad_out addr", ad_out, a[7:0]);
        chk("R3", "addr_hi T1", addr_hi, hi);
        chk("R4", "io_sel T1", io_sel, io);
        chk("R1", "req_ready busy", req_ready, 0);
        chk("R11", "dt_tx T1", dt_tx, w);
        chk("R2", "no strobe T1", {rd_stb, wr_stb, inta_stb}, 0);
        // T2 first half
        next_early();
        chk("R2", "ale T2", ale, 0);
        chk("R11", "den T2", den, 1);
        if (w) begin
            chk("R6", "wr_stb T2 edge", wr_stb, 1);
            chk("R6", "ad_oe T2", ad_oe, 1);
            chk("R6", "ad_out wdata T2", ad_out, wd);
        end else begin
            chk("R5", "ad_oe off T2", ad_oe, 0);
            chk("R5", "read strobe early T2", {rd_stb, inta_stb}, 0);
        end
        // T2 second half
        #10;
        if (k == K_RD) chk("R5", "rd_stb mid T2", rd_stb, 1);
        if (k == K_IA) begin
            chk("R9", "inta_stb mid T2", inta_stb, 1);
            chk("R9", "rd_stb in ack", rd_stb, 0);
        end
        // T3
        next_early();
        chk("R7", "strobe T3", rd_stb | wr_stb | inta_stb, 1);
        ready = (waits == 0);
        ad_in = rb;
        for (int j = 0; j < waits; j++) begin
            next_early();
            chk("R7", "strobe in Tw", rd_stb | wr_stb | inta_stb, 1);
            chk("R7", "no done in Tw", rsp_valid, 0);
            chk("R3", "addr_hi Tw", addr_hi, hi);
            ready = (j == waits - 1);
        end
        // T4
        next_early();
        ready = 1;
        chk("R7", "strobes off T4", {rd_stb, wr_stb, inta_stb}, 0);
        chk(k == K_IA ? "R9" : "R8", "rsp_valid T4", rsp_valid, fin);
        if (fin && !w) chk(k == K_IA ? "R9" : "R8", "rsp_data", rsp_data, rb);
        if (w) begin
            chk("R6", "ad_oe T4", ad_oe, 1);
            chk("R6", "ad_out T4", ad_out, wd);
            chk("R11", "den T4 write", den, 1);
        end else begin
            chk("R5", "ad_oe T4 read", ad_oe, 0);
            chk("R11", "den T4 read", den, 0);
        end
        chk("R4", "io_sel T4", io_sel, io);
        chk("R3", "addr_hi T4", addr_hi, hi);
        ad_in = 8'h00;
        next_early();
        if (fin) begin
            chk("R8", "done one clock", rsp_valid, 0);
            chk("R1", "idle after cycle", req_ready, 1);
            chk("R3", "addr_hi held idle", addr_hi, hi);
        end
    endtask

    task automatic t_reset();
        chk("R1", "reset req_ready", req_ready, 1);
        chk("R1", "reset outputs", {ale, rd_stb, wr_stb, inta_stb, ad_oe, rsp_valid}, 0);
    endtask

    task automatic t_read(input logic io, input logic [19:0] a,
                          input logic [7:0] rb, input int waits);
        launch(K_RD, io, a, 8'h00);
        phase(K_RD, io, a, 8'h00, rb, waits, 1, a[19:8]);
        last_hi = a[19:8];
    endtask

    task automatic t_write(input logic io, input logic [19:0] a,
                           input logic [7:0] wd, input int waits);
        launch(K_WR, io, a, wd);
        phase(K_WR, io, a, wd, 8'h00, waits, 1, a[19:8]);
        last_hi = a[19:8];
    endtask

    task automatic t_inta(input logic [7:0] first_b, input logic [7:0] type_b,
                          input int waits);
        launch(K_IA, 1'b0, 20'hFFFFF, 8'h00);
        phase(K_IA, 1'b0, 20'hFFFFF, 8'h00, first_b, waits, 0, last_hi);
        phase(K_IA, 1'b0, 20'hFFFFF, 8'h00, type_b, waits, 1, last_hi);
        chk("R10", "vec_ptr", vec_ptr, {type_b, 2'b00});
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        rst = 1; req_valid = 0; req_kind = 0; req_io = 0; req_addr = 0;
        req_wdata = 0; ready = 1; ad_in = 0;
        repeat (3) @(posedge clk);
        #4 rst = 0;
        t_reset();
        t_read(1'b0, 20'hA5C3, 8'h3C, 0);
        t_read(1'b1, 20'h0_1F7E, 8'hE1, 3);
        t_write(1'b0, 20'h7_2B10, 8'h96, 0);
        t_write(1'b1, 20'hC_4401, 8'h5A, 2);
        t_inta(8'hAA, 8'h21, 1);
        t_inta(8'h00, 8'hFF, 0);
        finish_run();
    end
endmodule